// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block sits between a bus arbiter and an execution controller. It reads 16-bit instruction words from memory and builds instructions that are one, two or three words long. The bus behind it can be 8 or 16 bits wide. It looks at the first word of each instruction to work out how many more words to read. Immediate operands are among those words, so they reach the consumer together with the opcode.

Fetching runs ahead of execution. While the consumer holds one finished instruction, the block is already reading the next one. A program-counter load drops everything fetched so far and restarts at the new address. A vector request reads a two-word vector in place of an instruction.

The bus width input `bus_wide` is static. It may change only while reset is asserted.

Top module: `ifs_fetch_seq`

## Requirements
- R1: After reset, `out_valid`, `bus_req` and `align_err` are 0, and no bus request is made until a program-counter load or a vector request arrives.
- R2: Every instruction starts with a 2-byte word fetched at the current fetch address. Bits [15:14] of that word set the total length: 2'b11 gives 3 words, 2'b10 gives 2 words, and 2'b0x gives 1 word.
- R3: Words are read from consecutive even addresses, 2 apart. The next instruction starts right after the last word of the previous one.
- R4: With `bus_wide`=1, each word is one access with `bus_size`=1 at an even address. The word comes back on `bus_rdata[15:0]`.
- R5: With `bus_wide`=0, each word is two byte accesses with `bus_size`=0, and the byte data comes back on `bus_rdata[7:0]`. The even-address byte is read first and becomes bits [15:8]; the odd-address byte becomes bits [7:0].
- R6: `out_data` holds the first word in [47:32], the second in [31:16] and the third in [15:0], with unused slots zero. `out_words` gives the count (1 to 3). The output stays stable while `out_valid`=1 and `out_ready`=0.
- R7: An instruction is presented only after all of its words have arrived.
- R8: While a presented instruction waits, the next instruction is fetched into one internal buffer. Once both are full, no bus request is made.
- R9: A `pc_load` discards any presented or partly built instruction, so `out_valid` is 0 in the next cycle. Fetching restarts at the new address. A bus access that was granted but has not completed is finished and its data dropped.
- R10: A load to an odd address sets `align_err` from the next cycle and issues no bus request. The next even load clears the error.
- R11: `vec_req` reads two words at `vec_addr` and presents them with `out_vec`=1 and `out_words`=2. After that, fetching stops until the next load. `pc_load` wins over `vec_req` in the same cycle.
- R12: `bus_req` stays high with a stable address and size until `bus_gnt`. After a grant without `bus_done`, no new request is made until `bus_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wide | input | 1 | 1: 16-bit bus, 0: 8-bit bus (static) |
| pc_load | input | 1 | Load new fetch address, flush |
| pc_load_addr | input | 24 | New fetch address |
| vec_req | input | 1 | Start a vector fetch, flush |
| vec_addr | input | 24 | Vector location |
| bus_req | output | 1 | Access request to the arbiter |
| bus_addr | output | 24 | Access byte address |
| bus_size | output | 1 | 1: word access, 0: byte access |
| bus_gnt | input | 1 | Request accepted |
| bus_done | input | 1 | Read data valid |
| bus_rdata | input | 16 | Read data |
| out_valid | output | 1 | Instruction available |
| out_ready | input | 1 | Consumer takes the instruction |
| out_data | output | 48 | Opcode and operand words |
| out_words | output | 2 | Word count, 1 to 3 |
| out_vec | output | 1 | Output is a vector |
| align_err | output | 1 | Odd load address seen |

## Verification
A wrong length decode or a wrong word counter shows up at the ports as a misplaced or missing word in the first instruction that has that length. Every later instruction in the stream then goes out of step, so the fault stays visible. A byte-order or half-select fault corrupts the very first word on an 8-bit bus. A flush that leaves state behind shows up as an instruction from the old stream appearing after a load. A buffering fault shows up as the wrong number of bus accesses in a stall window of a few dozen cycles.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

    typedef enum logic [1:0] {
        BP_IDLE  = 2'd0,
        BP_REQ   = 2'd1,
        BP_WAIT  = 2'd2,
        BP_DRAIN = 2'd3
    } bp_state_e;

    localparam logic SIZE_BYTE = 1'b0;
    localparam logic SIZE_WORD = 1'b1;

endpackage

// File: rtl/ifs_len_decode.sv
module ifs_len_decode #(
    parameter int CNT_W = 2
) (
    input  logic [1:0]       top_bits,
    output logic [CNT_W-1:0] total_words
);
    always_comb begin
        unique case (top_bits)
            2'b11:   total_words = CNT_W'(3);
            2'b10:   total_words = CNT_W'(2);
            default: total_words = CNT_W'(1);
        endcase
    end
endmodule

// File: rtl/ifs_bus_port.sv
module ifs_bus_port
    import ifs_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wide,
    input  logic              word_req,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic              flush,
    output logic              word_done,
    output logic [WORD_W-1:0] word_data,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_size,
    input  logic              bus_gnt,
    input  logic              bus_done,
    input  logic [WORD_W-1:0] bus_rdata
);
    localparam int BYTE_W = WORD_W / 2;

    typedef struct packed {
        bp_state_e         state;
        logic              half;
        logic [BYTE_W-1:0] hi;
        logic [ADDR_W-1:0] addr;
    } bp_t;

    bp_t q, d;

    logic capture;

    always_comb begin
        d         = q;
        capture   = 1'b0;
        word_done = 1'b0;
        bus_req   = (q.state == BP_REQ);
        bus_addr  = {q.addr[ADDR_W-1:1], q.half};
        bus_size  = bus_wide ? SIZE_WORD : SIZE_BYTE;
        word_data = bus_wide ? bus_rdata : {q.hi, bus_rdata[BYTE_W-1:0]};
        unique case (q.state)
            BP_IDLE: begin
                if (word_req && !flush) begin
                    d.state = BP_REQ;
                    d.addr  = word_addr;
                    d.half  = 1'b0;
                end
            end
            BP_REQ: begin
                if (flush) begin
                    d.state = (bus_gnt && !bus_done) ? BP_DRAIN : BP_IDLE;
                    d.half  = 1'b0;
                end else if (bus_gnt) begin
                    if (bus_done) capture = 1'b1;
                    else          d.state = BP_WAIT;
                end
            end
            BP_WAIT: begin
                if (flush) begin
                    d.state = bus_done ? BP_IDLE : BP_DRAIN;
                    d.half  = 1'b0;
                end else if (bus_done) begin
                    capture = 1'b1;
                end
            end
            default: begin
                if (bus_done) d.state = BP_IDLE;
            end
        endcase
        if (capture) begin
            if (bus_wide || q.half) begin
                word_done = 1'b1;
                d.state   = BP_IDLE;
                d.half    = 1'b0;
            end else begin
                d.hi    = bus_rdata[BYTE_W-1:0];
                d.half  = 1'b1;
                d.state = BP_REQ;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state <= BP_IDLE;
            q.half  <= 1'b0;
            q.hi    <= '0;
            q.addr  <= '0;
        end else begin
            q <= d;
        end
    end

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !flush) |=> (bus_req && $stable(bus_addr) && $stable(bus_size)));

    // R12
    no_req_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && !bus_done) |=> !bus_req);

    // R4
    wide_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_wide) |-> (bus_size == SIZE_WORD && !bus_addr[0]));

endmodule

// File: rtl/ifs_out_stage.sv
module ifs_out_stage #(
    parameter int DATA_W = 48,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic [CNT_W-1:0]  push_words,
    input  logic              push_vec,
    output logic              slot_free,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [CNT_W-1:0]  out_words,
    output logic              out_vec
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [CNT_W-1:0]  words;
        logic              vec;
    } os_t;

    os_t q, d;

    always_comb begin
        d         = q;
        slot_free = !q.valid || out_ready;
        if (flush) begin
            d.valid = 1'b0;
        end else if (push) begin
            d.valid = 1'b1;
            d.data  = push_data;
            d.words = push_words;
            d.vec   = push_vec;
        end else if (out_ready) begin
            d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.valid <= 1'b0;
            q.data  <= '0;
            q.words <= '0;
            q.vec   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.valid;
    assign out_data  = q.data;
    assign out_words = q.words;
    assign out_vec   = q.vec;

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data) && $stable(out_words)));

endmodule

// File: rtl/ifs_fetch_seq.sv
module ifs_fetch_seq #(
    parameter int ADDR_W    = 24,
    parameter int WORD_W    = 16,
    parameter int MAX_WORDS = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_wide,
    input  logic                            pc_load,
    input  logic [ADDR_W-1:0]               pc_load_addr,
    input  logic                            vec_req,
    input  logic [ADDR_W-1:0]               vec_addr,
    output logic                            bus_req,
    output logic [ADDR_W-1:0]               bus_addr,
    output logic                            bus_size,
    input  logic                            bus_gnt,
    input  logic                            bus_done,
    input  logic [WORD_W-1:0]               bus_rdata,
    output logic                            out_valid,
    input  logic                            out_ready,
    output logic [WORD_W*MAX_WORDS-1:0]     out_data,
    output logic [$clog2(MAX_WORDS+1)-1:0]  out_words,
    output logic                            out_vec,
    output logic                            align_err
);
    localparam int DATA_W   = WORD_W * MAX_WORDS;
    localparam int CNT_W    = $clog2(MAX_WORDS + 1);
    localparam int STEP     = WORD_W / 8;
    localparam int VEC_LEN  = 2;

    typedef struct packed {
        logic              active;
        logic              vec;
        logic              full;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  need;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] data;
        logic              err;
    } sq_t;

    sq_t q, d;

    logic              flush;
    logic [ADDR_W-1:0] flush_addr;
    logic              word_req;
    logic              word_done;
    logic [WORD_W-1:0] word_data;
    logic [CNT_W-1:0]  dec_words;
    logic [CNT_W-1:0]  first_need;
    logic              push;
    logic              slot_free;

    assign flush      = pc_load || vec_req;
    assign flush_addr = pc_load ? pc_load_addr : vec_addr;

    ifs_len_decode #(.CNT_W(CNT_W)) len_i (
        .top_bits    (word_data[WORD_W-1 -: 2]),
        .total_words (dec_words)
    );

    ifs_bus_port #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) port_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wide  (bus_wide),
        .word_req  (word_req),
        .word_addr (q.pc),
        .flush     (flush),
        .word_done (word_done),
        .word_data (word_data),
        .bus_req   (bus_req),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_gnt   (bus_gnt),
        .bus_done  (bus_done),
        .bus_rdata (bus_rdata)
    );

    ifs_out_stage #(.DATA_W(DATA_W), .CNT_W(CNT_W)) out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .push       (push),
        .push_data  (q.data),
        .push_words (q.cnt),
        .push_vec   (q.vec),
        .slot_free  (slot_free),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_words  (out_words),
        .out_vec    (out_vec)
    );

    always_comb begin
        d          = q;
        push       = 1'b0;
        word_req   = q.active && !q.full;
        first_need = q.vec ? CNT_W'(VEC_LEN) : dec_words;
        if (flush) begin
            d.active = !flush_addr[0];
            d.vec    = !pc_load;
            d.full   = 1'b0;
            d.cnt    = '0;
            d.need   = '0;
            d.pc     = flush_addr;
            d.data   = '0;
            d.err    = flush_addr[0];
        end else begin
            if (q.full && slot_free) begin
                push   = 1'b1;
                d.full = 1'b0;
                d.cnt  = '0;
                d.data = '0;
            end
            if (word_done) begin
                for (int k = 0; k < MAX_WORDS; k++) begin
                    if (q.cnt == CNT_W'(k)) d.data[DATA_W-1-k*WORD_W -: WORD_W] = word_data;
                end
                if (q.cnt == '0) d.need = first_need;
                d.cnt = CNT_W'(q.cnt + 1'b1);
                d.pc  = q.pc + ADDR_W'(STEP);
                if (CNT_W'(q.cnt + 1'b1) == ((q.cnt == '0) ? first_need : q.need)) begin
                    d.full = 1'b1;
                    if (q.vec) d.active = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.active <= 1'b0;
            q.vec    <= 1'b0;
            q.full   <= 1'b0;
            q.cnt    <= '0;
            q.need   <= '0;
            q.pc     <= '0;
            q.data   <= '0;
            q.err    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign align_err = q.err;

    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> !bus_req);

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !out_valid);

    // R7
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_words != '0 && out_words <= CNT_W'(MAX_WORDS)));

    // R11
    vec_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_vec) |-> (out_words == CNT_W'(VEC_LEN)));

    // R6
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_words == CNT_W'(1)) |-> (out_data[DATA_W-WORD_W-1:0] == '0));

endmodule

// File: tb/ifs_fetch_seq_tb_top.sv
module ifs_fetch_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int WW = 16;
    localparam int DW = 48;
    localparam int NV = 6;

    // fields: wide[31] split[30] lat[29:28] rdy[27:26] addr[25:10] count[9:0]
    localparam logic [31:0] VEC_TBL [NV] = '{
        {1'b1, 1'b0, 2'd0, 2'd0, 16'h0000, 10'd12},
        {1'b1, 1'b1, 2'd1, 2'd1, 16'h0124, 10'd10},
        {1'b0, 1'b0, 2'd0, 2'd0, 16'h0040, 10'd8},
        {1'b0, 1'b1, 2'd2, 2'd2, 16'h0ffe, 10'd6},
        {1'b1, 1'b0, 2'd2, 2'd2, 16'h2000, 10'd8},
        {1'b0, 1'b0, 2'd1, 2'd1, 16'h7ffa, 10'd6}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wide = 1'b1;
    logic          pc_load = 1'b0;
    logic [AW-1:0] pc_load_addr = '0;
    logic          vec_req = 1'b0;
    logic [AW-1:0] vec_addr = '0;
    logic          bus_req;
    logic [AW-1:0] bus_addr;
    logic          bus_size;
    logic          bus_gnt = 1'b0;
    logic          bus_done = 1'b0;
    logic [WW-1:0] bus_rdata = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;
    logic [1:0]    out_words;
    logic          out_vec;
    logic          align_err;

    ifs_fetch_seq dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wide(bus_wide),
        .pc_load(pc_load), .pc_load_addr(pc_load_addr),
        .vec_req(vec_req), .vec_addr(vec_addr),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_rdata(bus_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_words(out_words), .out_vec(out_vec), .align_err(align_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    int acc_cnt = 0;
    int viol = 0;
    int got = 0;
    int m_lat = 0;
    int rdy_mode = 0;
    logic m_split = 1'b0;
    logic hold_rdy = 1'b0;
    logic collect_en = 1'b0;
    logic exp_vec = 1'b0;
    logic [AW-1:0] exp_pc = '0;
    string tag = "R2";

    function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
        logic [31:0] p;
        p = {17'b0, a[15:1]} * 32'd40503;
        return p[15:0] ^ 16'h5a5a;
    endfunction

    function automatic int len_of(input logic [15:0] w);
        return w[15] ? (w[14] ? 3 : 2) : 1;
    endfunction

    function automatic logic [DW-1:0] exp_instr(input logic [AW-1:0] a);
        int n;
        logic [DW-1:0] r;
        n = len_of(mem_word(a));
        r = {mem_word(a), 32'h0};
        if (n > 1) r[31:16] = mem_word(a + 2);
        if (n > 2) r[15:0]  = mem_word(a + 4);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // bus memory model
    int m_ph = 0;
    int m_cnt = 0;
    logic [AW-1:0] m_addr = '0;
    logic m_size = 1'b0;
    logic [AW-1:0] m_prev = '0;

    function automatic logic [15:0] rd(input logic [AW-1:0] a, input logic sz);
        logic [15:0] w;
        w = mem_word({a[AW-1:1], 1'b0});
        if (sz) return w;
        return a[0] ? {8'h00, w[7:0]} : {8'h00, w[15:8]};
    endfunction

    always @(negedge clk) begin
        bus_gnt  = 1'b0;
        bus_done = 1'b0;
        if (!rst_n) begin
            m_ph = 0;
            m_cnt = 0;
        end else begin
            case (m_ph)
                0: begin
                    if (bus_req) begin
                        if (m_cnt > 0 && bus_addr != m_prev) viol++;
                        m_prev = bus_addr;
                        if (m_cnt >= m_lat) begin
                            bus_gnt = 1'b1;
                            m_addr = bus_addr;
                            m_size = bus_size;
                            m_cnt = 0;
                            acc_cnt++;
                            if (m_split) m_ph = 1;
                            else begin
                                bus_done = 1'b1;
                                bus_rdata = rd(bus_addr, bus_size);
                                m_ph = 2;
                            end
                        end else m_cnt++;
                    end else m_cnt = 0;
                end
                1: begin
                    if (bus_req) viol++;
                    bus_done = 1'b1;
                    bus_rdata = rd(m_addr, m_size);
                    m_ph = 2;
                end
                default: m_ph = 0;
            endcase
        end
    end

    // consumer and collector
    int rc = 0;
    always @(negedge clk) begin
        logic r;
        int n;
        logic [DW-1:0] e;
        rc++;
        case (rdy_mode)
            0: r = 1'b1;
            1: r = rc[0];
            default: r = (rc % 3 == 0);
        endcase
        if (hold_rdy || !collect_en || !rst_n) r = 1'b0;
        out_ready = r;
        if (r && out_valid) begin
            if (exp_vec) begin
                e = {mem_word(exp_pc), mem_word(exp_pc + 2), 16'h0};
                check(got == 0 && out_vec && out_words == 2 && out_data == e, "R11",
                      {13'b0, out_vec, out_words, out_data}, {13'b0, 1'b1, 2'd2, e});
            end else begin
                n = len_of(mem_word(exp_pc));
                e = exp_instr(exp_pc);
                check(!out_vec && out_words == 2'(n) && out_data == e, tag,
                      {13'b0, out_vec, out_words, out_data}, {13'b0, 1'b0, 2'(n), e});
                exp_pc = exp_pc + AW'(2 * n);
            end
            got++;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        collect_en = 1'b0;
        hold_rdy = 1'b0;
        pc_load = 1'b0;
        vec_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic load(input logic [AW-1:0] a);
        @(posedge clk);
        collect_en = 1'b0;
        @(negedge clk);
        pc_load = 1'b1;
        pc_load_addr = a;
        @(negedge clk);
        pc_load = 1'b0;
        exp_pc = a;
        exp_vec = 1'b0;
        got = 0;
        collect_en = 1'b1;
    endtask

    task automatic wait_got(input int n, input int maxc);
        int c;
        c = 0;
        while (got < n && c < maxc) begin
            @(negedge clk);
            c++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base, n1, n2;
        logic seen;
        // R1: reset state
        repeat (2) @(negedge clk);
        check(!out_valid && !bus_req && !align_err, "R1", {out_valid, bus_req, align_err}, 0);
        rst_n = 1'b1;
        seen = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (bus_req) seen = 1'b1;
        end
        check(!seen, "R1", seen, 0);

        // R10: odd address raises error, no fetch
        m_lat = 0; m_split = 1'b0; rdy_mode = 0;
        load(24'h000011);
        check(align_err == 1'b1, "R10", align_err, 1);
        seen = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (bus_req || out_valid) seen = 1'b1;
        end
        check(!seen, "R10", seen, 0);
        load(24'h000010);
        check(align_err == 1'b0, "R10", align_err, 0);
        wait_got(3, 500);
        check(got >= 3, "R10", got, 3);

        // table of stream vectors
        for (int i = 0; i < NV; i++) begin
            rst_n = 1'b0;
            bus_wide = VEC_TBL[i][31];
            m_split  = VEC_TBL[i][30];
            m_lat    = int'(VEC_TBL[i][29:28]);
            rdy_mode = int'(VEC_TBL[i][27:26]);
            tag = VEC_TBL[i][31] ? "R2 R3 R4 R7" : "R2 R3 R5 R7";
            do_reset();
            load({8'h00, VEC_TBL[i][25:10]});
            wait_got(int'(VEC_TBL[i][9:0]), 4000);
            check(got >= int'(VEC_TBL[i][9:0]), "R3", got, VEC_TBL[i][9:0]);
        end

        // R8: run-ahead and stall
        rst_n = 1'b0;
        bus_wide = 1'b1; m_split = 1'b0; m_lat = 0; rdy_mode = 0;
        tag = "R9";
        do_reset();
        hold_rdy = 1'b1;
        base = acc_cnt;
        load(24'h000100);
        repeat (60) @(negedge clk);
        n1 = len_of(mem_word(24'h000100));
        n2 = len_of(mem_word(24'h000100 + AW'(2 * n1)));
        check(out_valid && out_data == exp_instr(24'h000100), "R6", out_data, exp_instr(24'h000100));
        check(acc_cnt - base == n1 + n2, "R8", acc_cnt - base, n1 + n2);
        check(!bus_req, "R8", bus_req, 0);

        // R9: flush of held output and buffer
        load(24'h000200);
        check(!out_valid, "R9", out_valid, 0);
        hold_rdy = 1'b0;
        wait_got(4, 1000);
        check(got >= 4, "R9", got, 4);

        // R11: vector fetch on a byte bus with split handshake
        rst_n = 1'b0;
        bus_wide = 1'b0; m_split = 1'b1; m_lat = 1;
        do_reset();
        base = acc_cnt;
        @(posedge clk);
        collect_en = 1'b0;
        @(negedge clk);
        vec_req = 1'b1;
        vec_addr = 24'h000080;
        @(negedge clk);
        vec_req = 1'b0;
        exp_pc = 24'h000080;
        exp_vec = 1'b1;
        got = 0;
        collect_en = 1'b1;
        wait_got(1, 500);
        repeat (40) @(negedge clk);
        check(got == 1, "R11", got, 1);
        check(acc_cnt - base == 4, "R5", acc_cnt - base, 4);
        check(!bus_req, "R11", bus_req, 0);

        // R9: load while a split access is outstanding
        rst_n = 1'b0;
        bus_wide = 1'b0; m_split = 1'b1; m_lat = 0; rdy_mode = 0;
        tag = "R9";
        do_reset();
        load(24'h000300);
        repeat (7) @(negedge clk);
        load(24'h000500);
        wait_got(5, 2000);
        check(got >= 5, "R9", got, 5);

        check(viol == 0, "R12", viol, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule